// File: doc/BRIEF.md
# Crossing History Capture Register

This block sits on the framework side of the term alignment logic. On every framework tick it takes in one aligned term word, 64 bits by default, and pushes it into a short shift register of fixed length. The length is chosen at build time to cover the delay between a beam crossing and the arrival of the trigger accept for it. A capture strobe copies three taps of that register on one clock edge. The three taps are the triggered crossing, the crossing before it and the crossing after it.

There are two independent capture strobes. The event strobe fills a record that drives the event-readout path directly. The monitor strobe fills a second record holding the same three term states. A host reads that record 32 bits at a time through a word index. The host read spans many crossings, so a monitor capture sets a busy flag. While the flag is set, further monitor strobes are dropped and the record stays intact. The flag clears when the host issues a release, or when it reads the last word.

Top module: `bxh_capture`

## Requirements
- R1: While reset is low, and on the first sample after it, all record outputs, `evt_valid`, `host_rdata` and `mon_busy` read zero, and the read index is 0.
- R2: On a clock edge with `tick` high, `term_in` enters the newest stage and every stage moves one place older. With `tick` low the history holds.
- R3: On an edge with `evt_cap` high, the event record takes the history as it stood before that edge. With the defaults (depth 3, trigger tap 1), `evt_next` takes the newest stage, `evt_trig` the middle stage and `evt_prev` the oldest stage. A `tick` on the same edge does not disturb the captured values.
- R4: `evt_valid` is high for exactly the one cycle that follows each edge on which `evt_cap` was high.
- R5: With `evt_cap` low, the event record outputs keep their values whatever `tick` and `term_in` do.
- R6: A `mon_cap` while `mon_busy` is low latches the same three taps into the monitor record, sets `mon_busy` and sets the read index to 0.
- R7: A `mon_cap` while `mon_busy` is high is ignored, and every monitor word read back afterwards is unchanged.
- R8: `host_rdata` shows the monitor word chosen by the read index: 0 trig[31:0], 1 trig[63:32], 2 prev[31:0], 3 prev[63:32], 4 next[31:0], 5 next[63:32].
- R9: A `host_rd` moves the index up by one. A `host_rd` at index 5 returns the index to 0, and if `mon_busy` was set it clears it.
- R10: `host_idx_wr` loads the index from `host_idx`. A value above 5 loads 0. A load takes priority over a `host_rd` in the same cycle.
- R11: `host_release` clears `mon_busy`, and the next `mon_cap` is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Framework clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Crossing enable; shifts the history |
| term_in | input | 64 | Aligned term word for this crossing |
| evt_cap | input | 1 | Event-readout capture strobe |
| mon_cap | input | 1 | Monitoring capture strobe |
| evt_prev | output | 64 | Event record: crossing before the trigger |
| evt_trig | output | 64 | Event record: triggered crossing |
| evt_next | output | 64 | Event record: crossing after the trigger |
| evt_valid | output | 1 | One-cycle pulse after an event capture |
| host_rd | input | 1 | Host read strobe; advances the index |
| host_idx_wr | input | 1 | Host write of the read index |
| host_idx | input | 3 | Index value for `host_idx_wr` |
| host_release | input | 1 | Host write that clears the busy flag |
| host_rdata | output | 32 | Monitor word at the current index |
| mon_busy | output | 1 | Monitor record held for the host |

## Verification
The bench fires an event capture on the same edge as a tick. A design that sampled the history after the shift would report every crossing one place late. It also captures on crossings with `tick` low, where a design that shifted anyway would lose a word. A monitor strobe is issued in the middle of a host read. A design without the interlock would mix two data sets in one readout. The wrap of the index at the sixth word, the clearing of busy on that read, and out-of-range index loads are checked directly. An off-by-one in the index would clear busy a word early or point past the record.

// File: rtl/bxh_pkg.sv
package bxh_pkg;

  // Record slot selected by a word index; each slot spans several halves.
  function automatic int unsigned slot_of(int unsigned idx, int unsigned halves);
    return idx / halves;
  endfunction

  function automatic int unsigned half_of(int unsigned idx, int unsigned halves);
    return idx % halves;
  endfunction

  // Index after a host read: wraps from the last word back to zero.
  function automatic int unsigned next_idx(int unsigned idx, int unsigned last);
    return (idx >= last) ? 0 : idx + 1;
  endfunction

  // Index loaded by the host: anything past the record maps to zero.
  function automatic int unsigned clamp_idx(int unsigned idx, int unsigned last);
    return (idx > last) ? 0 : idx;
  endfunction

endpackage

// File: rtl/bxh_history.sv
module bxh_history #(
  parameter int W     = 64,
  parameter int DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift,
  input  logic [W-1:0]               din,
  output logic [DEPTH-1:0][W-1:0]    stage
);

  // Stage 0 holds the newest crossing, stage DEPTH-1 the oldest.
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [W-1:0] feed;
    if (s == 0) begin : g_head
      assign feed = din;
    end else begin : g_body
      assign feed = stage[s-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     stage[s] <= '0;
      else if (shift) stage[s] <= feed;
    end
  end

endmodule

// File: rtl/bxh_snap.sv
module bxh_snap #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] prev_q,
  output logic [W-1:0] trig_q,
  output logic [W-1:0] next_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      trig_q <= '0;
      next_q <= '0;
    end else if (load) begin
      prev_q <= prev_i;
      trig_q <= trig_i;
      next_q <= next_i;
    end
  end

endmodule

// File: rtl/bxh_monport.sv
module bxh_monport
  import bxh_pkg::*;
#(
  parameter int W     = 64,
  parameter int RD_W  = 32,
  parameter int WORDS = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_req,
  input  logic             rd,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             release_i,
  input  logic [W-1:0]     rec_prev,
  input  logic [W-1:0]     rec_trig,
  input  logic [W-1:0]     rec_next,
  output logic             busy,
  output logic [RD_W-1:0]  rdata,
  output logic             cap_fire,
  output logic             cap_drop,
  output logic             last_read
);

  localparam int HALVES = W / RD_W;
  localparam int LAST   = WORDS - 1;

  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     word_sel;

  assign cap_fire  = cap_req && !busy;
  assign cap_drop  = cap_req && busy;
  assign last_read = rd && busy && (32'(idx_q) == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                      busy <= 1'b0;
    else if (cap_fire)               busy <= 1'b1;
    else if (release_i || last_read) busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_q <= '0;
    else if (cap_fire) idx_q <= '0;
    else if (idx_wr)   idx_q <= IDX_W'(clamp_idx(32'(idx_val), LAST));
    else if (rd)       idx_q <= IDX_W'(next_idx(32'(idx_q), LAST));
  end

  always_comb begin
    case (slot_of(32'(idx_q), HALVES))
      0:       word_sel = rec_trig;
      1:       word_sel = rec_prev;
      default: word_sel = rec_next;
    endcase
    rdata = word_sel[half_of(32'(idx_q), HALVES)*RD_W +: RD_W];
  end

endmodule

// File: rtl/bxh_capture.sv
module bxh_capture #(
  parameter  int TERM_W     = 64,
  parameter  int HIST_DEPTH = 3,
  parameter  int TRIG_TAP   = 1,
  parameter  int RD_W       = 32,
  localparam int WORDS      = 3 * (TERM_W / RD_W),
  localparam int IDX_W      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TERM_W-1:0] term_in,
  input  logic              evt_cap,
  input  logic              mon_cap,
  output logic [TERM_W-1:0] evt_prev,
  output logic [TERM_W-1:0] evt_trig,
  output logic [TERM_W-1:0] evt_next,
  output logic              evt_valid,
  input  logic              host_rd,
  input  logic              host_idx_wr,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic              host_release,
  output logic [RD_W-1:0]   host_rdata,
  output logic              mon_busy
);

  logic [HIST_DEPTH-1:0][TERM_W-1:0] hist_q;
  logic [TERM_W-1:0] tap_prev, tap_trig, tap_next;
  logic [TERM_W-1:0] mon_prev_q, mon_trig_q, mon_next_q;
  logic mon_fire, mon_drop, last_read;

  bxh_history #(.W(TERM_W), .DEPTH(HIST_DEPTH)) hist_i (
    .clk(clk), .rst_n(rst_n), .shift(tick), .din(term_in), .stage(hist_q)
  );

  // Older crossings sit at higher stage numbers.
  assign tap_prev = hist_q[TRIG_TAP+1];
  assign tap_trig = hist_q[TRIG_TAP];
  assign tap_next = hist_q[TRIG_TAP-1];

  bxh_snap #(.W(TERM_W)) evt_snap_i (
    .clk(clk), .rst_n(rst_n), .load(evt_cap),
    .prev_i(tap_prev), .trig_i(tap_trig), .next_i(tap_next),
    .prev_q(evt_prev), .trig_q(evt_trig), .next_q(evt_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) evt_valid <= 1'b0;
    else        evt_valid <= evt_cap;
  end

  bxh_snap #(.W(TERM_W)) mon_snap_i (
    .clk(clk), .rst_n(rst_n), .load(mon_fire),
    .prev_i(tap_prev), .trig_i(tap_trig), .next_i(tap_next),
    .prev_q(mon_prev_q), .trig_q(mon_trig_q), .next_q(mon_next_q)
  );

  bxh_monport #(.W(TERM_W), .RD_W(RD_W), .WORDS(WORDS), .IDX_W(IDX_W)) mon_port_i (
    .clk(clk), .rst_n(rst_n), .cap_req(mon_cap), .rd(host_rd),
    .idx_wr(host_idx_wr), .idx_val(host_idx), .release_i(host_release),
    .rec_prev(mon_prev_q), .rec_trig(mon_trig_q), .rec_next(mon_next_q),
    .busy(mon_busy), .rdata(host_rdata),
    .cap_fire(mon_fire), .cap_drop(mon_drop), .last_read(last_read)
  );

endmodule

// File: rtl/bxh_capture_chk.sv
module bxh_capture_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] term_in,
  input logic [W-1:0] hist_newest,
  input logic         evt_cap,
  input logic         evt_valid,
  input logic [W-1:0] evt_trig,
  input logic         mon_busy,
  input logic         host_release,
  input logic         mon_fire,
  input logic         mon_drop,
  input logic         last_read,
  input logic [W-1:0] mon_prev,
  input logic [W-1:0] mon_trig,
  input logic [W-1:0] mon_next
);

  // R2
  hist_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> hist_newest == $past(term_in));

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hist_newest));

  // R4
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cap |=> evt_valid);

  // R4
  evt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_cap |=> !evt_valid);

  // R5
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_cap |=> $stable(evt_trig));

  // R6
  mon_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_fire |=> mon_busy);

  // R7
  mon_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_drop |=> ($stable(mon_prev) && $stable(mon_trig) && $stable(mon_next)));

  // R9
  last_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_read |=> !mon_busy);

  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_release && mon_busy) |=> !mon_busy);

endmodule

bind bxh_capture bxh_capture_chk #(.W(TERM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .term_in(term_in),
  .hist_newest(hist_q[0]), .evt_cap(evt_cap), .evt_valid(evt_valid),
  .evt_trig(evt_trig), .mon_busy(mon_busy), .host_release(host_release),
  .mon_fire(mon_fire), .mon_drop(mon_drop), .last_read(last_read),
  .mon_prev(mon_prev_q), .mon_trig(mon_trig_q), .mon_next(mon_next_q)
);

// File: tb/bxh_capture_tb_top.sv
module bxh_capture_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [63:0] term_in = '0;
  logic        evt_cap = 1'b0, mon_cap = 1'b0;
  logic [63:0] evt_prev, evt_trig, evt_next;
  logic        evt_valid;
  logic        host_rd = 1'b0, host_idx_wr = 1'b0, host_release = 1'b0;
  logic [2:0]  host_idx = '0;
  logic [31:0] host_rdata;
  logic        mon_busy;

  int nchk = 0;
  int nfail = 0;

  // Bench model of the history: hm[0] newest.
  logic [63:0] hm [3];
  logic [63:0] ep, et, en;   // expected event record
  logic [63:0] mp, mt, mn;   // expected monitor record

  always #4 clk = ~clk;

  bxh_capture dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .term_in(term_in),
    .evt_cap(evt_cap), .mon_cap(mon_cap),
    .evt_prev(evt_prev), .evt_trig(evt_trig), .evt_next(evt_next),
    .evt_valid(evt_valid), .host_rd(host_rd), .host_idx_wr(host_idx_wr),
    .host_idx(host_idx), .host_release(host_release),
    .host_rdata(host_rdata), .mon_busy(mon_busy)
  );

  // {tick, evt_cap, word}
  localparam logic [65:0] VEC [12] = '{
    {1'b1, 1'b0, 64'h0123_4567_89ab_cdef},
    {1'b1, 1'b0, 64'hfedc_ba98_7654_3210},
    {1'b1, 1'b0, 64'h0000_0000_ffff_ffff},
    {1'b1, 1'b1, 64'hffff_ffff_0000_0000},
    {1'b0, 1'b1, 64'hdead_beef_cafe_f00d},
    {1'b0, 1'b0, 64'h0000_0000_0000_0001},
    {1'b1, 1'b0, 64'h8000_0000_0000_0001},
    {1'b1, 1'b1, 64'h0f0f_0f0f_f0f0_f0f0},
    {1'b1, 1'b0, 64'h3c3c_5a5a_a5a5_c3c3},
    {1'b0, 1'b1, 64'h7777_7777_7777_7777},
    {1'b1, 1'b0, 64'h1357_9bdf_2468_ace0},
    {1'b1, 1'b1, 64'h5555_aaaa_5555_aaaa}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, sample 2 ns after the edge, drop strobes.
  task automatic cyc(logic t, logic [63:0] w, logic ec, logic mc,
                     logic rd, logic iw, logic [2:0] iv, logic rel);
    tick = t; term_in = w; evt_cap = ec; mon_cap = mc;
    host_rd = rd; host_idx_wr = iw; host_idx = iv; host_release = rel;
    @(posedge clk);
    #2;
    tick = 0; evt_cap = 0; mon_cap = 0; host_rd = 0; host_idx_wr = 0; host_release = 0;
  endtask

  task automatic push(logic [63:0] w);
    cyc(1'b1, w, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    hm[2] = hm[1]; hm[1] = hm[0]; hm[0] = w;
  endtask

  function automatic logic [31:0] mword(int i);
    logic [63:0] s;
    s = (i / 2 == 0) ? mt : (i / 2 == 1) ? mp : mn;
    return (i % 2 == 0) ? s[31:0] : s[63:32];
  endfunction

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) hm[i] = '0;
    ep = '0; et = '0; en = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state while held
    chk("R1 evt_trig", evt_trig, 64'd0);
    chk("R1 evt_valid", {63'd0, evt_valid}, 64'd0);
    chk("R1 mon_busy", {63'd0, mon_busy}, 64'd0);
    chk("R1 rdata", {32'd0, host_rdata}, 64'd0);
    rst_n = 1'b1;

    // R2/R3/R4/R5: vector table
    for (int i = 0; i < 12; i++) begin
      logic t, c;
      logic [63:0] w;
      t = VEC[i][65]; c = VEC[i][64]; w = VEC[i][63:0];
      if (c) begin ep = hm[2]; et = hm[1]; en = hm[0]; end
      cyc(t, w, c, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
      if (t) begin hm[2] = hm[1]; hm[1] = hm[0]; hm[0] = w; end
      chk("R4 evt_valid", {63'd0, evt_valid}, {63'd0, c});
      chk(c ? "R3 evt_prev" : "R5 evt_prev", evt_prev, ep);
      chk(c ? "R3 evt_trig" : "R5 evt_trig", evt_trig, et);
      chk(c ? "R2 R3 evt_next" : "R5 evt_next", evt_next, en);
    end

    // R6: monitor capture while idle
    mp = hm[2]; mt = hm[1]; mn = hm[0];
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R6 busy set", {63'd0, mon_busy}, 64'd1);
    chk("R8 word0", {32'd0, host_rdata}, {32'd0, mword(0)});
    // R8/R9: walk words 1..5
    for (int k = 1; k < 6; k++) begin
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
      chk("R8 word", {32'd0, host_rdata}, {32'd0, mword(k)});
      chk("R9 busy kept", {63'd0, mon_busy}, 64'd1);
    end
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
    chk("R9 busy cleared on last", {63'd0, mon_busy}, 64'd0);
    chk("R9 index wrapped", {32'd0, host_rdata}, {32'd0, mword(0)});

    // R7: new record, then strobe while busy
    push(64'haaaa_0000_bbbb_1111);
    push(64'hcccc_2222_dddd_3333);
    mp = hm[2]; mt = hm[1]; mn = hm[0];
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    push(64'heeee_4444_ffff_5555);
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R7 busy held", {63'd0, mon_busy}, 64'd1);
    for (int k = 0; k < 6; k++) begin
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 3'(k), 1'b0);
      chk("R7 R10 word unchanged", {32'd0, host_rdata}, {32'd0, mword(k)});
    end
    // R10: out-of-range load, and load beats read
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 1'b0);
    chk("R10 clamp", {32'd0, host_rdata}, {32'd0, mword(0)});
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0);
    chk("R10 load over read", {32'd0, host_rdata}, {32'd0, mword(3)});
    chk("R10 busy kept", {63'd0, mon_busy}, 64'd1);

    // R11: release then accept
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
    chk("R11 released", {63'd0, mon_busy}, 64'd0);
    mp = hm[2]; mt = hm[1]; mn = hm[0];
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R11 reaccepted", {63'd0, mon_busy}, 64'd1);
    chk("R11 new word0", {32'd0, host_rdata}, {32'd0, mword(0)});

    // R1: reset mid-operation
    rst_n = 1'b0;
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R1 busy after reset", {63'd0, mon_busy}, 64'd0);
    chk("R1 evt_prev after reset", evt_prev, 64'd0);
    chk("R1 rdata after reset", {32'd0, host_rdata}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule